// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block drives the command sequences of a command-set parallel flash through a byte access engine below it. A caller picks one of four operations with a two-bit select and pulses a start strobe. The block then issues command writes and data reads over a request/acknowledge link to the engine. When the sequence is over, it returns one or two result bytes, a busy-time count and a one-cycle done pulse.

The four operations are identification, status, restore array and wait for ready. Identification returns the manufacturer and device codes. Status returns one status byte. Restore array puts the part back into plain array reads. Wait for ready polls the status register after a program or erase until the ready flag is set, and counts the polls. Every operation that changes the read mode of the part finishes by writing the array-read command, so the part is always left in normal read mode. Each poll is one engine access, so the count measures busy time in units of one poll period.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy, done, both result bytes and the busy-time count are zero, and no access is requested.
- R2: Operation code 0 (identification) writes 0x90, reads address 0 into the low result, reads address 2 into the high result, then writes 0xFF. That is two writes and two reads.
- R3: Operation code 1 (status) writes 0x70, reads address 0 once into the low result, then writes 0xFF.
- R4: Operation code 2 (restore array) performs exactly one access, a write of 0xFF, and no reads.
- R5: Every command write targets address 0, and its data is always one of 0x90, 0x70 or 0xFF.
- R6: Operation code 3 (wait for ready) clears the count, writes 0x70, then reads address 0 repeatedly while bit 7 of the returned byte is 0. The count rises by one for each read, including the read that sees the ready flag. That read is stored as the low result, and a write of 0xFF follows.
- R7: The busy-time count saturates at its all-ones value instead of wrapping.
- R8: Done is a single-cycle pulse in the cycle after the final 0xFF write is acknowledged. Busy is high from the cycle after an accepted start until done, and low with done.
- R9: A start pulse while busy is ignored. The running operation completes unchanged.
- R10: Result bytes and the count hold their values while idle and are cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | Operation: 0 ident, 1 status, 2 restore array, 3 wait ready |
| start | input | 1 | Start strobe, accepted only while idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | DATA_W | Manufacturer code or status byte |
| res_hi | output | DATA_W | Device code |
| busy_time | output | CNT_W | Poll count of the last wait |
| acc_req | output | 1 | Access request to byte engine, held until acknowledged |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | ADDR_W | Access address |
| acc_wdata | output | DATA_W | Command byte to write |
| acc_ack | input | 1 | Engine completes the access this cycle |
| acc_rdata | input | DATA_W | Read data, valid with acc_ack |

## Verification
The bench builds the block with a 4-bit busy counter and otherwise default widths. With that counter, saturation at 15 is reached within a few dozen cycles. A sweep of busy-poll counts from 0 to 17 then covers the exact-count region, the boundary at 14 to 16 polls, and the saturated region past it. The engine model answers after two cycles and follows the mode each command sets, so every sequence's write and read counts and the final array mode are observed at the ports.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_IDENT  = 2'd0,
      OP_STATUS = 2'd1,
      OP_ARRAY  = 2'd2,
      OP_WAIT   = 2'd3
   } fseq_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_RD_A,
      ST_RD_B,
      ST_EXIT
   } fseq_state_e;

   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_STATUS = 8'h70;
   localparam logic [7:0] CMD_ARRAY  = 8'hFF;

endpackage

// File: rtl/fseq_busy_ctr.sv
module fseq_busy_ctr #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("fseq_busy_ctr: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n || clr)               cnt_q <= '0;
         else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clr) cnt_q <= '0;
         else if (inc)      cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R7
   if (SATURATE) begin : g_sat_chk
      cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
   end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 8,
   parameter int RDY_BIT = 7,
   parameter int ID2_ADR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_sel,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic              cnt_clr,
   output logic              cnt_inc,
   output logic              acc_req,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_ack,
   input  logic [DATA_W-1:0] acc_rdata
);

   localparam logic [ADDR_W-1:0] BASE_ADR = '0;
   localparam logic [ADDR_W-1:0] HI_ADR   = ADDR_W'(ID2_ADR);

   if (DATA_W < 8) begin : g_bad_d
      $error("fseq_ctrl: DATA_W must hold an 8-bit command");
   end
   if (RDY_BIT >= DATA_W) begin : g_bad_r
      $error("fseq_ctrl: RDY_BIT outside data width");
   end

   fseq_state_e       state_q, state_d;
   fseq_op_e          op_q;
   logic              done_q;
   logic [DATA_W-1:0] lo_q, hi_q;
   logic              hit, accept;

   assign hit    = acc_req && acc_ack;
   assign accept = start && state_q == ST_IDLE;

   always_comb begin
      acc_req   = state_q != ST_IDLE;
      acc_wr    = state_q == ST_CMD || state_q == ST_EXIT;
      acc_addr  = (state_q == ST_RD_B) ? HI_ADR : BASE_ADR;
      if (state_q == ST_EXIT)       acc_wdata = DATA_W'(CMD_ARRAY);
      else if (op_q == OP_IDENT)    acc_wdata = DATA_W'(CMD_IDENT);
      else                          acc_wdata = DATA_W'(CMD_STATUS);
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = (fseq_op_e'(op_sel) == OP_ARRAY) ? ST_EXIT : ST_CMD;
         ST_CMD:  if (hit)   state_d = ST_RD_A;
         ST_RD_A: if (hit) begin
            unique case (op_q)
               OP_IDENT: state_d = ST_RD_B;
               OP_WAIT:  state_d = acc_rdata[RDY_BIT] ? ST_EXIT : ST_RD_A;
               default:  state_d = ST_EXIT;
            endcase
         end
         ST_RD_B: if (hit)   state_d = ST_EXIT;
         ST_EXIT: if (hit)   state_d = ST_IDLE;
         default:            state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_IDENT;
         done_q  <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= hit && state_q == ST_EXIT;
         if (accept) begin
            op_q <= fseq_op_e'(op_sel);
            lo_q <= '0;
            hi_q <= '0;
         end
         if (hit && state_q == ST_RD_A) lo_q <= acc_rdata;
         if (hit && state_q == ST_RD_B) hi_q <= acc_rdata;
      end
   end

   assign cnt_clr = accept;
   assign cnt_inc = hit && state_q == ST_RD_A && op_q == OP_WAIT;
   assign busy    = state_q != ST_IDLE;
   assign done    = done_q;
   assign res_lo  = lo_q;
   assign res_hi  = hi_q;

   // R5
   wr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_wr) |-> acc_addr == BASE_ADR);

   // R5
   wr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_wr) |-> (acc_wdata == DATA_W'(CMD_IDENT) ||
                               acc_wdata == DATA_W'(CMD_STATUS) ||
                               acc_wdata == DATA_W'(CMD_ARRAY)));

   // R8
   done_after_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(acc_req && acc_ack && acc_wr && acc_wdata == DATA_W'(CMD_ARRAY)));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_q));

   // R10
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res_lo) && $stable(res_hi)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int RDY_BIT  = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_sel,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic [CNT_W-1:0]  busy_time,
   output logic              acc_req,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_ack,
   input  logic [DATA_W-1:0] acc_rdata
);

   if (ADDR_W < 2) begin : g_bad_a
      $error("flash_seq: ADDR_W must reach address 2");
   end

   logic cnt_clr, cnt_inc;

   fseq_ctrl #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RDY_BIT (RDY_BIT),
      .ID2_ADR (2)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_sel    (op_sel),
      .start     (start),
      .busy      (busy),
      .done      (done),
      .res_lo    (res_lo),
      .res_hi    (res_hi),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc),
      .acc_req   (acc_req),
      .acc_wr    (acc_wr),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_ack   (acc_ack),
      .acc_rdata (acc_rdata)
   );

   fseq_busy_ctr #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (busy_time)
   );

endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;

   localparam int ADDR_W = 24;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;
   localparam logic [7:0] MFG = 8'h89;
   localparam logic [7:0] DEV = 8'h17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] op_sel = 2'd0;
   logic start = 1'b0;
   logic busy, done, acc_req, acc_wr, acc_ack;
   logic [DATA_W-1:0] res_lo, res_hi, acc_wdata, acc_rdata;
   logic [CNT_W-1:0] busy_time;
   logic [ADDR_W-1:0] acc_addr;

   always #5 clk = ~clk;

   flash_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .start(start),
      .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
      .busy_time(busy_time), .acc_req(acc_req), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
      .acc_rdata(acc_rdata)
   );

   // flash + engine model: mode 0 array, 1 ident, 2 status
   int mode = 0, n_wr = 0, n_rd = 0, poll_i = 0, busy_n = 0, bad = 0;
   logic [2:0] wc;

   always @(posedge clk) begin
      if (!rst_n || !acc_req || acc_ack) wc <= '0;
      else wc <= wc + 3'd1;
   end
   assign acc_ack = acc_req && wc == 3'd1;

   always_comb begin
      if (mode == 1)      acc_rdata = (acc_addr == 0) ? MFG : (acc_addr == 2) ? DEV : 8'h00;
      else if (mode == 2) acc_rdata = (poll_i < busy_n) ? 8'h00 : 8'h80;
      else                acc_rdata = acc_addr[7:0] ^ 8'h5A;
   end

   always @(posedge clk) begin
      if (rst_n && acc_req && acc_ack) begin
         if (acc_wr) begin
            n_wr = n_wr + 1;
            if (acc_addr != 0) bad = bad + 1;
            case (acc_wdata)
               8'h90: mode = 1;
               8'h70: mode = 2;
               8'hFF: mode = 0;
               default: bad = bad + 1;
            endcase
         end else begin
            n_rd = n_rd + 1;
            if (mode == 2) poll_i = poll_i + 1;
         end
      end
   end

   int n_chk = 0, n_bad = 0;
   bit timed_out = 1'b0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic launch(int op);
      n_wr = 0; n_rd = 0; poll_i = 0;
      op_sel = op[1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R8 busy after start", int'(busy), 1);
   endtask

   task automatic wait_done();
      int lim = 0;
      while (!done && lim < 500) begin
         @(negedge clk);
         lim++;
      end
      if (!done) begin
         timed_out = 1'b1;
         chk("R8 done reached", 0, 1);
      end
   endtask

   task automatic after_done();
      chk("R8 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk("R8 done single cycle", int'(done), 0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 res_lo", int'(res_lo), 0);
      chk("R1 res_hi", int'(res_hi), 0);
      chk("R1 count", int'(busy_time), 0);
      chk("R1 req", int'(acc_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 identification
      launch(0); wait_done();
      chk("R2 manufacturer", int'(res_lo), int'(MFG));
      chk("R2 device", int'(res_hi), int'(DEV));
      chk("R2 writes", n_wr, 2);
      chk("R2 reads", n_rd, 2);
      chk("R2 array mode", mode, 0);
      after_done();

      // R10 clear on start: array op after ident
      launch(2); wait_done();
      chk("R4 writes", n_wr, 1);
      chk("R4 reads", n_rd, 0);
      chk("R4 array mode", mode, 0);
      chk("R10 res_lo cleared", int'(res_lo), 0);
      chk("R10 res_hi cleared", int'(res_hi), 0);
      after_done();

      // R3 status, ready and busy values
      for (int b = 0; b < 2; b++) begin
         busy_n = b;
         launch(1); wait_done();
         chk("R3 status byte", int'(res_lo), b == 0 ? 8'h80 : 8'h00);
         chk("R3 writes", n_wr, 2);
         chk("R3 reads", n_rd, 1);
         chk("R3 array mode", mode, 0);
         after_done();
      end

      // R6 / R7 sweep of busy poll counts
      for (int n = 0; n < 18; n++) begin
         busy_n = n;
         launch(3); wait_done();
         chk("R6 poll reads", n_rd, n + 1);
         chk("R6 writes", n_wr, 2);
         chk("R6 ready byte", int'(res_lo), 8'h80);
         chk("R7 count", int'(busy_time), (n + 1 > CMAX) ? CMAX : n + 1);
         chk("R6 array mode", mode, 0);
         after_done();
      end

      // R9 start while busy ignored
      busy_n = 5;
      launch(3);
      repeat (3) @(negedge clk);
      op_sel = 2'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R9 count kept", int'(busy_time), 6);
      chk("R9 reads", n_rd, 6);
      chk("R9 res_hi untouched", int'(res_hi), 0);
      after_done();

      // R10 hold while idle
      repeat (6) @(negedge clk);
      chk("R10 count held", int'(busy_time), 6);
      chk("R10 res_lo held", int'(res_lo), 8'h80);
      launch(2); wait_done();
      chk("R10 count cleared", int'(busy_time), 0);

      // R5 command writes address and codes
      chk("R5 bad writes", bad, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule